// File: doc/BRIEF.md
# UART Mode Control and Output Gating

This block holds the 8-bit mode register of a serial port and the logic driven by its upper bits. It gates the interrupt pin together with a general-purpose output. It also chooses how the serial lines are routed: to the wired pins, through an infrared path, or back into the receiver for self-test.

The same register controls three more functions. It can resume a transmitter that flow control has stopped, whenever any character arrives. It decides whether each received character is stored. It slows the baud generator's reference by a factor of four.

The host writes and reads the register through a simple strobe port. The transmitter, receiver and flow-control logic of the port connect to the remaining pins. The baud divisor, the character framing and the infrared pulse shaping are handled by other blocks.

Top module: `uart_mode_ctl`

## Requirements
- R1: All eight register bits are 0 after reset. A read returns the value most recently written, one cycle after the write strobe.
- R2: With bit 3 at 0, `intPinOe` is 0, `intPin` is 0 and `gpOut` is 1. With bit 3 at 1, `intPinOe` is 1, `intPin` follows `intReq` and `gpOut` is 0.
- R3: With bit 4 at 1 (loopback), `rxSerial` equals `txSerial`, `txPin` is held at 1 and `irTxOut` is held at 0. `rxPin` and `irRxIn` have no effect, and loopback takes priority over bit 6.
- R4: With bit 6 at 1 and bit 4 at 0 (infrared), `irTxOut` is the inverse of `txSerial`, so it rests at 0 while the line idles at mark. `txPin` is held at 1, `rxSerial` is the inverse of `irRxIn`, and `rxPin` has no effect.
- R5: With bits 4 and 6 both 0, `txPin` equals `txSerial`, `rxSerial` equals `rxPin`, and `irTxOut` is 0.
- R6: With bit 5 at 1, a cycle with `rxCharValid` and `txHalted` both high gives a one-cycle `txResume` pulse in the following cycle, whatever the character value. With bit 5 at 0, or with `txHalted` low, `txResume` stays 0.
- R7: `rxStore` is high in the cycle after a cycle with `rxCharValid` high. The exception is when `swFlowEn` is 1 and the character equals `xonChar` or `xoffChar`; such a character is not stored.
- R8: With bit 7 at 0, `baudTick` is high every cycle. With bit 7 at 1, `baudTick` is high in exactly one cycle of every four, driven by a free-running counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write value |
| regRdData | output | 8 | Register read value |
| intReq | input | 1 | Internal interrupt request |
| intPin | output | 1 | Interrupt pin value |
| intPinOe | output | 1 | Interrupt pin drive enable (0 = high impedance) |
| gpOut | output | 1 | General-purpose output, inverse of bit 3 |
| txSerial | input | 1 | Serial data from the transmitter |
| txPin | output | 1 | Wired TX pin |
| irTxOut | output | 1 | Infrared TX output, idle low |
| rxPin | input | 1 | Wired RX pin |
| irRxIn | input | 1 | Infrared RX input, active high |
| rxSerial | output | 1 | Serial data to the receiver |
| rxCharValid | input | 1 | Received-character strobe |
| rxChar | input | 8 | Received character value |
| swFlowEn | input | 1 | Software Xon/Xoff flow control enabled |
| xonChar | input | 8 | Resume character |
| xoffChar | input | 8 | Stop character |
| txHalted | input | 1 | Transmitter stopped by flow control |
| txResume | output | 1 | Transmit-resume pulse |
| rxStore | output | 1 | Store the received character |
| baudTick | output | 1 | Clock enable for the baud generator |

## Verification
The resume pulse and the store decision can both be raised by the same received character. The bench provokes this with an ordinary character that arrives while the transmitter is halted and Xon-Any is set, then checks that both pulses appear in the same following cycle. It then sends a resume-control character with software flow control on, and checks that the resume pulse still fires while storage is withheld. Finally it repeats the character with flow control off, and with Xon-Any off, to separate the two decisions.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;
  localparam int MODE_W       = 8;
  localparam int BIT_INT_EN   = 3;
  localparam int BIT_LOOP     = 4;
  localparam int BIT_XON_ANY  = 5;
  localparam int BIT_IR       = 6;
  localparam int BIT_PRESCALE = 7;

  typedef struct packed {
    logic intEn;
    logic loopEn;
    logic irEn;
    logic divEn;
    logic resumeHit;
    logic storeHit;
  } modeStrobes_t;
endpackage

// File: rtl/uart_mode_ctrl.sv
module uart_mode_ctrl
  import uart_mode_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [MODE_W-1:0] regWrData,
  output logic [MODE_W-1:0] regRdData,
  input  logic              rxCharValid,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              swFlowEn,
  input  logic [CHAR_W-1:0] xonChar,
  input  logic [CHAR_W-1:0] xoffChar,
  input  logic              txHalted,
  output modeStrobes_t      strobes
);
  logic [MODE_W-1:0] modeReg;
  logic              isFlowChar;

  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= '0;
    else if (regWrEn) modeReg <= regWrData;
  end

  assign regRdData  = modeReg;
  assign isFlowChar = (rxChar == xonChar) || (rxChar == xoffChar);

  always_comb begin
    strobes.intEn     = modeReg[BIT_INT_EN];
    strobes.loopEn    = modeReg[BIT_LOOP];
    strobes.irEn      = modeReg[BIT_IR];
    strobes.divEn     = modeReg[BIT_PRESCALE];
    strobes.resumeHit = rxCharValid && txHalted && modeReg[BIT_XON_ANY];
    strobes.storeHit  = rxCharValid && !(swFlowEn && isFlowChar);
  end

  AST_RD_LAST_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData == $past(regWrData))); // R1
endmodule

// File: rtl/uart_mode_dp.sv
module uart_mode_dp
  import uart_mode_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  modeStrobes_t strobes,
  input  logic         intReq,
  input  logic         txSerial,
  input  logic         rxPin,
  input  logic         irRxIn,
  output logic         intPin,
  output logic         intPinOe,
  output logic         gpOut,
  output logic         txPin,
  output logic         irTxOut,
  output logic         rxSerial,
  output logic         txResume,
  output logic         rxStore,
  output logic         baudTick
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] divCnt;

  assign intPinOe = strobes.intEn;
  assign intPin   = strobes.intEn && intReq;
  assign gpOut    = !strobes.intEn;

  always_comb begin
    if (strobes.loopEn) begin
      txPin    = 1'b1;
      irTxOut  = 1'b0;
      rxSerial = txSerial;
    end else if (strobes.irEn) begin
      txPin    = 1'b1;
      irTxOut  = !txSerial;
      rxSerial = !irRxIn;
    end else begin
      txPin    = txSerial;
      irTxOut  = 1'b0;
      rxSerial = rxPin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txResume <= 1'b0;
      rxStore  <= 1'b0;
      divCnt   <= '0;
    end else begin
      txResume <= strobes.resumeHit;
      rxStore  <= strobes.storeHit;
      divCnt   <= (divCnt == CNT_LAST) ? '0 : divCnt + 1'b1;
    end
  end

  assign baudTick = !strobes.divEn || (divCnt == CNT_LAST);

  AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !intPinOe |-> (!intPin && gpOut)); // R2
  AST_LOOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loopEn |-> (txPin && !irTxOut && (rxSerial == txSerial))); // R3
  AST_IR_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.irEn && txSerial) |-> !irTxOut); // R4
  AST_RESUME_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    txResume |-> $past(strobes.resumeHit)); // R6
  AST_STORE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    rxStore |-> $past(strobes.storeHit)); // R7
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (baudTick && strobes.divEn) |=> (!baudTick || !strobes.divEn)); // R8
endmodule

// File: rtl/uart_mode_ctl.sv
module uart_mode_ctl
  import uart_mode_pkg::*;
#(
  parameter int CHAR_W   = 8,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              intReq,
  output logic              intPin,
  output logic              intPinOe,
  output logic              gpOut,
  input  logic              txSerial,
  output logic              txPin,
  output logic              irTxOut,
  input  logic              rxPin,
  input  logic              irRxIn,
  output logic              rxSerial,
  input  logic              rxCharValid,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              swFlowEn,
  input  logic [CHAR_W-1:0] xonChar,
  input  logic [CHAR_W-1:0] xoffChar,
  input  logic              txHalted,
  output logic              txResume,
  output logic              rxStore,
  output logic              baudTick
);
  modeStrobes_t strobes;

  uart_mode_ctrl #(.CHAR_W(CHAR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .rxCharValid(rxCharValid), .rxChar(rxChar),
    .swFlowEn(swFlowEn), .xonChar(xonChar), .xoffChar(xoffChar),
    .txHalted(txHalted), .strobes(strobes)
  );

  uart_mode_dp #(.PRESCALE(PRESCALE)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .intReq(intReq),
    .txSerial(txSerial), .rxPin(rxPin), .irRxIn(irRxIn), .intPin(intPin),
    .intPinOe(intPinOe), .gpOut(gpOut), .txPin(txPin), .irTxOut(irTxOut),
    .rxSerial(rxSerial), .txResume(txResume), .rxStore(rxStore),
    .baudTick(baudTick)
  );
endmodule

// File: tb/test_uart_mode_ctl.sv
module test_uart_mode_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic intReq = 1'b0, intPin, intPinOe, gpOut;
  logic txSerial = 1'b1, txPin, irTxOut;
  logic rxPin = 1'b1, irRxIn = 1'b0, rxSerial;
  logic rxCharValid = 1'b0;
  logic [7:0] rxChar = '0;
  logic swFlowEn = 1'b0;
  logic [7:0] xonChar = 8'h11, xoffChar = 8'h13;
  logic txHalted = 1'b0, txResume, rxStore, baudTick;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = !clk;

  uart_mode_ctl i_uart_mode_ctl (.*);

  typedef struct packed {
    logic [7:0] mode;
    logic tx, rx, ir, irq;
    logic [5:0] expOut; // txPin, irTxOut, rxSerial, intPin, intPinOe, gpOut
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 6'b001001},
    '{8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 6'b100001},
    '{8'h08, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000110},
    '{8'h08, 1'b1, 1'b1, 1'b0, 1'b0, 6'b101010},
    '{8'h10, 1'b0, 1'b1, 1'b0, 1'b1, 6'b100001},
    '{8'h10, 1'b1, 1'b0, 1'b1, 1'b0, 6'b101001},
    '{8'h40, 1'b0, 1'b1, 1'b1, 1'b0, 6'b110001},
    '{8'h40, 1'b1, 1'b0, 1'b0, 1'b1, 6'b101001},
    '{8'h50, 1'b0, 1'b1, 1'b1, 1'b0, 6'b100001},
    '{8'h58, 1'b1, 1'b0, 1'b1, 1'b1, 6'b101110}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeMode(input logic [7:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = v;
    @(posedge clk); #1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic sendChar(input logic [7:0] c, input logic halted, input logic flow,
                          input logic expResume, input logic expStore, input string tag);
    @(negedge clk);
    rxChar = c; rxCharValid = 1'b1; txHalted = halted; swFlowEn = flow;
    @(posedge clk); #1;
    check(tag, {6'b0, txResume, rxStore}, {6'b0, expResume, expStore});
    @(negedge clk);
    rxCharValid = 1'b0;
    @(posedge clk); #1;
    check({tag, " idle"}, {6'b0, txResume, rxStore}, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 R2: reset state
    check("R1 reset read", regRdData, 8'h00);
    check("R2 reset gating", {5'b0, intPinOe, intPin, gpOut}, 8'h01);
    @(negedge clk); rstN = 1'b1;

    // R2 R3 R4 R5 table walk
    foreach (VEC[i]) begin
      writeMode(VEC[i].mode);
      txSerial = VEC[i].tx; rxPin = VEC[i].rx; irRxIn = VEC[i].ir; intReq = VEC[i].irq;
      #2;
      check($sformatf("R2/R3/R4/R5 vector %0d", i),
            {2'b0, txPin, irTxOut, rxSerial, intPin, intPinOe, gpOut}, {2'b0, VEC[i].expOut});
    end

    // R1 readback
    writeMode(8'hA5);
    check("R1 readback A5", regRdData, 8'hA5);
    writeMode(8'h5A);
    check("R1 readback 5A", regRdData, 8'h5A);

    // R6 R7 Xon-Any and store decision
    writeMode(8'h20);
    sendChar(8'h41, 1'b1, 1'b1, 1'b1, 1'b1, "R6 R7 plain char halted");
    sendChar(8'h11, 1'b1, 1'b1, 1'b1, 1'b0, "R6 R7 xon char flow on");
    sendChar(8'h13, 1'b1, 1'b1, 1'b1, 1'b0, "R7 xoff char flow on");
    sendChar(8'h13, 1'b1, 1'b0, 1'b1, 1'b1, "R7 xoff char flow off");
    sendChar(8'h41, 1'b0, 1'b1, 1'b0, 1'b1, "R6 not halted");
    writeMode(8'h00);
    sendChar(8'h41, 1'b1, 1'b1, 1'b0, 1'b1, "R6 xon-any off");

    // R8 prescaler
    begin
      int ticks = 0;
      int adj = 0;
      logic prev = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(posedge clk); #1;
        if (baudTick) ticks++;
      end
      check("R8 undivided ticks", 8'(ticks), 8'd40);
      writeMode(8'h80);
      ticks = 0;
      for (int k = 0; k < 40; k++) begin
        @(posedge clk); #1;
        if (baudTick) ticks++;
        if (baudTick && prev) adj++;
        prev = baudTick;
      end
      check("R8 divided ticks", 8'(ticks), 8'd10);
      check("R8 no adjacent ticks", 8'(adj), 8'd0);
    end

    // R1 reset clears a full register
    writeMode(8'hFF);
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    check("R1 reset after FF", regRdData, 8'h00);
    check("R2 reset gating again", {5'b0, intPinOe, intPin, gpOut}, 8'h01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule